// File: doc/BRIEF.md
# Serial Packet Receive-and-Route Controller

This block watches a one-bit serial line that rests at 0. It takes in short fixed-format packets with a bit time of exactly one clock period. A packet opens with a 1. Three payload bits follow, earliest first, and a closing 0 ends it. Each payload bit is kept in its own enabled storage flip-flop. The closing bit is then checked. A packet whose closing bit is 1 is thrown away with no output activity. After such a packet the block waits for the line to fall back to 0 before it looks for another opening 1.

For a good packet, the last payload bit picks one of two serial output lines: 0 selects line A and 1 selects line B. The selected line carries a new packet. It is an opening 1, the first two payload bits in arrival order, their XOR, and a closing 0. Both outputs are registered and rest at 0. The new packet starts on the clock cycle right after the closing input bit was sampled. Upstream logic must space packets so that each retransmission ends before the next packet begins.

The payload width is a parameter (default 3). The last payload bit always routes, and the other bits are resent with their XOR appended.

Top module: `serialRouter`

## Requirements
- R1: While rstN is low, outA and outB read 0 at once, with no clock edge needed. After release the block is idle and waits for a packet.
- R2: While idle, a 0 on lineIn keeps both outputs at 0. A 1 sampled at a rising edge is taken as the opening bit.
- R3: The three clock edges after the opening bit capture B0, B1 and B2 into separate storage bits, in that order.
- R4: If the edge after B2 samples lineIn as 0, the selected output reads 1 from that edge until the next one. This is the outgoing opening bit.
- R5: With B2 = 0 the packet goes out on outA, and with B2 = 1 it goes out on outB. The other output stays 0 the whole time.
- R6: The outgoing packet is 1, B0, B1, parity, 0, with one bit per clock. The output is back at 0 after it.
- R7: The parity bit equals B0 XOR B1.
- R8: If the closing input bit is 1, neither output shows any activity for that packet.
- R9: After a bad closing bit, the block ignores lineIn while it stays 1. The first 0 returns it to idle without being treated as part of a packet, so a 1 on the very next edge opens a new packet.
- R10: Values on lineIn during the four edges after the outgoing opening bit is launched have no effect on the outgoing packet.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all sampling on the rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| lineIn | input | 1 | Serial input line, rests at 0 |
| outA | output | 1 | Serial output line A, registered, rests at 0 |
| outB | output | 1 | Serial output line B, registered, rests at 0 |

## Verification
The assertions assume that lineIn is synchronous to clk and changes once per bit time. They also assume that a new opening bit never arrives before the previous retransmission has launched its closing 0, four edges after the opening bit goes out. The stimulus drives lineIn only on falling clock edges. After every good packet it holds at least four idle or noise bits before the next opening bit, and after a bad packet it keeps the line at 1 for a random time before returning it to 0. Noise is placed only in the window where the controller is sending, so the spacing rule is never broken.

// File: rtl/serialRouterPkg.sv
package serialRouterPkg;

  // width of the bit index carried in the strobe bundle (payload up to 16 bits)
  localparam int IDX_W = 4;

  // what the output register loads on the next edge
  typedef enum logic [1:0] {
    SRC_ZERO = 2'd0,
    SRC_ONE  = 2'd1,
    SRC_DATA = 2'd2,
    SRC_PAR  = 2'd3
  } txSrcE;

  // control -> datapath strobes
  typedef struct packed {
    logic             capEn;
    logic [IDX_W-1:0] capIdx;
    logic             txEn;
    txSrcE            txSrc;
    logic [IDX_W-1:0] txIdx;
  } ctlStrbS;

endpackage

// File: rtl/serialRouterCtrl.sv
module serialRouterCtrl
  import serialRouterPkg::*;
#(
  parameter int PAY_BITS = 3
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    lineIn,
  output ctlStrbS strb
);

  localparam logic [IDX_W-1:0] LAST_RX = IDX_W'(PAY_BITS - 1);
  localparam logic [IDX_W-1:0] LAST_TX = IDX_W'(PAY_BITS - 2);

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_RECV  = 3'd1,
    ST_CHECK = 3'd2,
    ST_SEND  = 3'd3,
    ST_PAR   = 3'd4,
    ST_STOP  = 3'd5,
    ST_DROP  = 3'd6
  } stateE;

  stateE            state, nextState;
  logic [IDX_W-1:0] bitCnt, nextCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
    end else begin
      state  <= nextState;
      bitCnt <= nextCnt;
    end
  end

  always_comb begin
    nextState = state;
    nextCnt   = bitCnt;
    strb      = '0;
    unique case (state)
      ST_IDLE: begin
        nextCnt = '0;
        if (lineIn) nextState = ST_RECV;
      end
      ST_RECV: begin
        strb.capEn  = 1'b1;
        strb.capIdx = bitCnt;
        if (bitCnt == LAST_RX) begin
          nextState = ST_CHECK;
          nextCnt   = '0;
        end else begin
          nextCnt = bitCnt + IDX_W'(1);
        end
      end
      ST_CHECK: begin
        nextCnt = '0;
        if (!lineIn) begin
          strb.txEn  = 1'b1;
          strb.txSrc = SRC_ONE;
          nextState  = ST_SEND;
        end else begin
          nextState = ST_DROP;
        end
      end
      ST_SEND: begin
        strb.txEn  = 1'b1;
        strb.txSrc = SRC_DATA;
        strb.txIdx = bitCnt;
        if (bitCnt == LAST_TX) begin
          nextState = ST_PAR;
          nextCnt   = '0;
        end else begin
          nextCnt = bitCnt + IDX_W'(1);
        end
      end
      ST_PAR: begin
        strb.txEn  = 1'b1;
        strb.txSrc = SRC_PAR;
        nextState  = ST_STOP;
      end
      ST_STOP: begin
        strb.txEn  = 1'b1;
        strb.txSrc = SRC_ZERO;
        nextState  = ST_IDLE;
      end
      ST_DROP: begin
        if (!lineIn) nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  // R9: a dropped packet never resumes capture without passing through idle
  p_drop_no_capture_r9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DROP) |=> !strb.capEn);

  // R8: a bad closing bit launches nothing on the following cycle
  p_bad_stop_silent_r8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CHECK && lineIn) |=> !strb.txEn);

endmodule

// File: rtl/serialRouterData.sv
module serialRouterData
  import serialRouterPkg::*;
#(
  parameter int PAY_BITS = 3
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    lineIn,
  input  ctlStrbS strb,
  output logic    outA,
  output logic    outB
);

  localparam int DATA_BITS = PAY_BITS - 1;

  logic [PAY_BITS-1:0] payQ;
  logic                parBit;
  logic                routeB;
  logic                dataBit;
  logic                srcBit;

  // one enabled storage flip-flop per payload bit
  for (genvar g = 0; g < PAY_BITS; g++) begin : g_cap
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        payQ[g] <= 1'b0;
      else if (strb.capEn && (strb.capIdx == IDX_W'(g)))
        payQ[g] <= lineIn;
    end
  end

  assign parBit = ^payQ[DATA_BITS-1:0];
  assign routeB = payQ[PAY_BITS-1];

  always_comb begin
    dataBit = 1'b0;
    for (int i = 0; i < DATA_BITS; i++)
      if (strb.txIdx == IDX_W'(i)) dataBit = payQ[i];
  end

  always_comb begin
    unique case (strb.txSrc)
      SRC_ONE:  srcBit = 1'b1;
      SRC_DATA: srcBit = dataBit;
      SRC_PAR:  srcBit = parBit;
      default:  srcBit = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outA <= 1'b0;
      outB <= 1'b0;
    end else begin
      outA <= strb.txEn & ~routeB & srcBit;
      outB <= strb.txEn &  routeB & srcBit;
    end
  end

  // R5: the two lines are never active together
  p_one_line_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(outA && outB));

  // R4: launching the opening bit makes exactly one line high next cycle
  p_start_bit_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.txEn && strb.txSrc == SRC_ONE) |=> (outA || outB));

  // R7: the parity slot carries the XOR of the resent bits
  p_parity_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.txEn && strb.txSrc == SRC_PAR) |=> ((outA | outB) == $past(parBit)));

  // R8: with nothing being sent both lines rest low
  p_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    !strb.txEn |=> (!outA && !outB));

  // R10: stored payload does not move while a packet goes out
  p_hold_payload_r10: assert property (@(posedge clk) disable iff (!rstN)
    strb.txEn |=> $stable(payQ));

endmodule

// File: rtl/serialRouter.sv
module serialRouter
  import serialRouterPkg::*;
#(
  parameter int PAY_BITS = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic lineIn,
  output logic outA,
  output logic outB
);

  ctlStrbS strb;

  serialRouterCtrl #(.PAY_BITS(PAY_BITS)) ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .lineIn (lineIn),
    .strb   (strb)
  );

  serialRouterData #(.PAY_BITS(PAY_BITS)) data_i (
    .clk    (clk),
    .rstN   (rstN),
    .lineIn (lineIn),
    .strb   (strb),
    .outA   (outA),
    .outB   (outB)
  );

endmodule

// File: tb/serialRouter_tb_top.sv
module serialRouter_tb_top;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lineIn = 1'b0;
  logic outA, outB;
  int   checks = 0;
  int   fails = 0;

  always #5 clk = ~clk;

  serialRouter dut_i (
    .clk    (clk),
    .rstN   (rstN),
    .lineIn (lineIn),
    .outA   (outA),
    .outB   (outB)
  );

  task automatic chk(input logic got, input logic exp, input string tag, input string what);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %0b expected %0b", tag, what, got, exp);
    end
  endtask

  // expected level of one output, k samples after the opening bit was driven
  function automatic logic expLine(int k, logic b0, logic b1, logic b2,
                                   logic bad, logic lineSel);
    if (bad || (b2 != lineSel)) return 1'b0;
    case (k)
      5:       return 1'b1;
      6:       return b0;
      7:       return b1;
      8:       return b0 ^ b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string tagFor(int k, logic bad, logic onLine, logic noise);
    if (bad)                return "R8";
    if (!onLine)            return "R5";
    if (noise && k > 5)     return "R10";
    if (k == 5)             return "R4";
    if (k == 6 || k == 7)   return "R3";
    if (k == 8)             return "R7";
    return "R6";
  endfunction

  // drives one packet plus trailing bits; samples outputs before each drive
  task automatic runPkt(input logic b0, input logic b1, input logic b2,
                        input logic bad, input int hold, input int gap,
                        input logic noise);
    int total;
    logic drv;
    total = 5 + hold + gap;
    for (int k = 0; k < total; k++) begin
      @(negedge clk);
      chk(outA, expLine(k, b0, b1, b2, bad, 1'b0), tagFor(k, bad, !b2, noise), "outA");
      chk(outB, expLine(k, b0, b1, b2, bad, 1'b1), tagFor(k, bad, b2, noise), "outB");
      case (k)
        0:       drv = 1'b1;
        1:       drv = b0;
        2:       drv = b1;
        3:       drv = b2;
        4:       drv = bad;
        default: begin
          if (bad && k < 5 + hold)               drv = 1'b1;
          else if (noise && !bad && k >= 5 && k <= 8) drv = 1'($urandom);
          else                                   drv = 1'b0;
        end
      endcase
      lineIn = drv;
    end
  endtask

  initial begin
    #(200000 * 10);
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(outA, 1'b0, "R1", "outA in reset");
    chk(outB, 1'b0, "R1", "outB in reset");
    rstN = 1'b1;

    // R2: idle zeros produce nothing
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(outA, 1'b0, "R2", "outA idle");
      chk(outB, 1'b0, "R2", "outB idle");
    end

    // directed: every payload to both lines
    for (int v = 0; v < 8; v++)
      runPkt(v[0], v[1], v[2], 1'b0, 0, 4, 1'b0);

    // directed R8 and R9: bad stop, held high, single zero, then valid packet at once
    runPkt(1'b1, 1'b1, 1'b0, 1'b1, 3, 1, 1'b0);
    runPkt(1'b1, 1'b0, 1'b1, 1'b0, 0, 4, 1'b0);
    runPkt(1'b0, 1'b1, 1'b1, 1'b1, 0, 1, 1'b0);
    runPkt(1'b0, 1'b1, 1'b0, 1'b0, 0, 4, 1'b0);

    // directed R10: noise while sending
    runPkt(1'b1, 1'b0, 1'b0, 1'b0, 0, 4, 1'b1);
    runPkt(1'b0, 1'b1, 1'b1, 1'b0, 0, 5, 1'b1);

    // R1: asynchronous reset in the middle of an outgoing packet
    runPkt(1'b1, 1'b0, 1'b0, 1'b0, 0, 0, 1'b0);
    @(negedge clk);
    chk(outA, 1'b1, "R4", "outA before reset");
    lineIn = 1'b0;
    #2 rstN = 1'b0;
    #1;
    chk(outA, 1'b0, "R1", "outA async reset");
    chk(outB, 1'b0, "R1", "outB async reset");
    @(negedge clk);
    rstN = 1'b1;
    runPkt(1'b0, 1'b0, 1'b1, 1'b0, 0, 4, 1'b0);

    // random mix
    for (int n = 0; n < 60; n++) begin
      logic rb0, rb1, rb2, rbad, rnz;
      int rhold, rgap;
      rb0   = 1'($urandom);
      rb1   = 1'($urandom);
      rb2   = 1'($urandom);
      rbad  = ($urandom % 4) == 0;
      rnz   = ($urandom % 3) == 0;
      rhold = rbad ? int'($urandom % 4) : 0;
      rgap  = rbad ? 1 + int'($urandom % 3) : 4 + int'($urandom % 3);
      runPkt(rb0, rb1, rb2, rbad, rhold, rgap, rnz);
    end

    @(negedge clk);
    chk(outA, 1'b0, "R6", "outA final rest");
    chk(outB, 1'b0, "R6", "outB final rest");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule